// File: doc/BRIEF.md
# Utilization-Based Interrupt Moderator

This block paces completion interrupts for one traffic direction of a network port. It counts completed frames and compares the count against a threshold. The threshold comes from one of four utilization bands, and the band is chosen from the current link-utilization percentage. When the count reaches the band's threshold, the block emits a one-cycle utilization interrupt. A second, independent source counts microsecond ticks and emits a one-cycle timer interrupt at the end of each programmed interval. By default it does so only if frames completed during that interval. A continuous mode makes it fire on every interval, and an auto-cancel mode restarts the interval whenever a utilization interrupt is raised.

A timer state machine tracks the timer source. It has three states. T_OFF means the timer is stopped, because the block is disabled or the interval is zero. T_QUIET means an interval is running and no frame has completed in it yet. T_BUSY means an interval is running and at least one frame has completed in it. The named transitions are:

- **arm** (T_OFF to T_QUIET): the block is enabled and the interval is non-zero.
- **traffic** (T_QUIET to T_BUSY): a frame completes.
- **expire** (T_QUIET or T_BUSY to T_QUIET): the interval elapses.
- **cancel** (T_QUIET or T_BUSY to T_QUIET): auto-cancel is on and a utilization interrupt is raised.
- **halt** (any state to T_OFF): the block is disabled or the interval is zero.

Top module: `intr_moderator`

## Requirements
- R1: Band selection compares `util_pct` with `lim_a`, `lim_b` and `lim_c`, in that order. The first limit that `util_pct` does not exceed selects band A, B or C; a limit equal to `util_pct` counts as not exceeded. If all three limits are exceeded, band D is selected.
- R2: A `frame_done` pulse that brings the frame count to at least the selected band's threshold raises `util_irq` for exactly the following cycle. A threshold of 0 behaves like a threshold of 1.
- R3: The frame count returns to zero whenever either interrupt is issued.
- R4: With `continuous` low, `timer_irq` pulses on the `us_tick` that completes `interval` ticks, but only if a frame completed during that interval. A frame in the expiring cycle counts. The next interval then starts with no traffic recorded.
- R5: With `continuous` high, `timer_irq` pulses every `interval` ticks whether or not frames completed.
- R6: With `auto_cancel` high, a utilization interrupt restarts the tick count of the current interval. No timer interrupt is issued in that cycle.
- R7: When `interval` is 0, the timer source is off and `timer_irq` stays low.
- R8: While `enable` is low, both outputs are low, and the frame count and the tick count are held at zero.
- R9: After reset, both outputs are low and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable for the whole block |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| util_pct | input | 7 | Link utilization in percent |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| lim_a | input | 7 | Upper utilization limit of band A |
| lim_b | input | 7 | Upper utilization limit of band B |
| lim_c | input | 7 | Upper utilization limit of band C |
| thr_a | input | 16 | Frame threshold of band A |
| thr_b | input | 16 | Frame threshold of band B |
| thr_c | input | 16 | Frame threshold of band C |
| thr_d | input | 16 | Frame threshold of band D |
| interval | input | 16 | Timer interval in microsecond ticks; 0 turns the timer off |
| continuous | input | 1 | Timer fires every interval, with or without traffic |
| auto_cancel | input | 1 | A utilization interrupt restarts the timer interval |
| util_irq | output | 1 | Utilization interrupt pulse |
| timer_irq | output | 1 | Timer interrupt pulse |

## Verification
The assertions assume the following about the inputs:

- `frame_done` and `us_tick` are synchronous, single-cycle-wide events.
- The configuration inputs are stable in the cycle before an interrupt is checked, so the `$past` values of `auto_cancel` and `interval` describe the state the block was in.

The stimulus respects these assumptions. It changes configuration only while `enable` is low, or in idle cycles away from ticks and frames. It drives every event as a one-cycle pulse applied one time unit after the clock edge.

// File: rtl/imod_pkg.sv
package imod_pkg;
    typedef enum logic [1:0] {BAND_A, BAND_B, BAND_C, BAND_D} band_e;
    typedef enum logic [1:0] {T_OFF, T_QUIET, T_BUSY} tstate_e;
endpackage

// File: rtl/imod_band_sel.sv
module imod_band_sel
    import imod_pkg::*;
#(
    parameter int PCT_W = 7,
    parameter int CNT_W = 16
) (
    input  logic [PCT_W-1:0] util_pct,
    input  logic [PCT_W-1:0] lim_a,
    input  logic [PCT_W-1:0] lim_b,
    input  logic [PCT_W-1:0] lim_c,
    input  logic [CNT_W-1:0] thr_a,
    input  logic [CNT_W-1:0] thr_b,
    input  logic [CNT_W-1:0] thr_c,
    input  logic [CNT_W-1:0] thr_d,
    output band_e            band,
    output logic [CNT_W-1:0] thr
);
    // Ascending priority: first limit not exceeded wins.
    always_comb begin
        if (util_pct <= lim_a)      band = BAND_A;
        else if (util_pct <= lim_b) band = BAND_B;
        else if (util_pct <= lim_c) band = BAND_C;
        else                        band = BAND_D;
    end

    always_comb begin
        unique case (band)
            BAND_A:  thr = thr_a;
            BAND_B:  thr = thr_b;
            BAND_C:  thr = thr_c;
            default: thr = thr_d;
        endcase
    end
endmodule

// File: rtl/imod_frame_cnt.sv
module imod_frame_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] thr,
    input  logic             tmr_fire,
    output logic             hit
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, cnt_q} + SUM_W'(1);
    assign hit = enable && frame_done && (sum >= {1'b0, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || hit || tmr_fire) begin
            cnt_q <= '0;
        end else if (frame_done && !sum[CNT_W]) begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/imod_timer.sv
module imod_timer
    import imod_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             us_tick,
    input  logic [TMR_W-1:0] interval,
    input  logic             continuous,
    input  logic             auto_cancel,
    input  logic             frame_done,
    input  logic             util_hit,
    output logic             fire
);
    localparam int SUM_W = TMR_W + 1;

    tstate_e          state_q, state_d;
    logic [TMR_W-1:0] tick_q;
    logic [SUM_W-1:0] tick_sum;
    logic             run, expire, cancel, restart;

    assign run      = enable && (interval != '0);
    assign tick_sum = {1'b0, tick_q} + SUM_W'(1);
    assign expire   = (state_q != T_OFF) && us_tick && (tick_sum >= {1'b0, interval});
    assign cancel   = (state_q != T_OFF) && auto_cancel && util_hit;
    assign restart  = expire || cancel;
    assign fire     = run && expire && !cancel &&
                      (continuous || state_q == T_BUSY || frame_done);

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = T_OFF;                         // halt
        end else begin
            unique case (state_q)
                T_OFF:   state_d = T_QUIET;          // arm
                T_QUIET: if (restart)         state_d = T_QUIET;
                         else if (frame_done) state_d = T_BUSY;  // traffic
                T_BUSY:  if (restart)         state_d = T_QUIET; // expire / cancel
                default: state_d = T_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            tick_q <= '0;
        else if (state_q == T_OFF || !run || restart) tick_q <= '0;
        else if (us_tick)                      tick_q <= tick_sum[TMR_W-1:0];
    end
endmodule

// File: rtl/intr_moderator.sv
module intr_moderator
    import imod_pkg::*;
#(
    parameter int PCT_W = 7,
    parameter int CNT_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             frame_done,
    input  logic [PCT_W-1:0] util_pct,
    input  logic             us_tick,
    input  logic [PCT_W-1:0] lim_a,
    input  logic [PCT_W-1:0] lim_b,
    input  logic [PCT_W-1:0] lim_c,
    input  logic [CNT_W-1:0] thr_a,
    input  logic [CNT_W-1:0] thr_b,
    input  logic [CNT_W-1:0] thr_c,
    input  logic [CNT_W-1:0] thr_d,
    input  logic [TMR_W-1:0] interval,
    input  logic             continuous,
    input  logic             auto_cancel,
    output logic             util_irq,
    output logic             timer_irq
);
    band_e            band;
    logic [CNT_W-1:0] thr;
    logic             hit, tfire;

    imod_band_sel #(.PCT_W(PCT_W), .CNT_W(CNT_W)) u_band (
        .util_pct(util_pct), .lim_a(lim_a), .lim_b(lim_b), .lim_c(lim_c),
        .thr_a(thr_a), .thr_b(thr_b), .thr_c(thr_c), .thr_d(thr_d),
        .band(band), .thr(thr)
    );

    imod_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_done(frame_done),
        .thr(thr), .tmr_fire(tfire), .hit(hit)
    );

    imod_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .enable(enable), .us_tick(us_tick),
        .interval(interval), .continuous(continuous), .auto_cancel(auto_cancel),
        .frame_done(frame_done), .util_hit(hit), .fire(tfire)
    );

    // Output register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            util_irq  <= 1'b0;
            timer_irq <= 1'b0;
        end else if (!enable) begin
            util_irq  <= 1'b0;
            timer_irq <= 1'b0;
        end else begin
            util_irq  <= hit;
            timer_irq <= tfire;
        end
    end
endmodule

// File: rtl/intr_moderator_chk.sv
module intr_moderator_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             frame_done,
    input logic             us_tick,
    input logic [TMR_W-1:0] interval,
    input logic             auto_cancel,
    input logic             util_irq,
    input logic             timer_irq
);
    // R2: a utilization interrupt always follows a completed frame
    p_util_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        util_irq |-> $past(frame_done));

    // R4: a timer interrupt always follows a tick
    p_timer_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> $past(us_tick));

    // R7: zero interval never yields a timer interrupt
    p_zero_interval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> $past(interval) != '0);

    // R8: disabled block issues nothing
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!util_irq && !timer_irq));

    // R6: auto-cancel suppresses a coincident timer interrupt
    p_cancel_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (util_irq && $past(auto_cancel)) |-> !timer_irq);
endmodule

bind intr_moderator intr_moderator_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_done(frame_done),
    .us_tick(us_tick), .interval(interval), .auto_cancel(auto_cancel),
    .util_irq(util_irq), .timer_irq(timer_irq)
);

// File: tb/tb_intr_moderator.sv
`timescale 1ns/1ps
module tb_intr_moderator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        frame_done = 1'b0;
    logic [6:0]  util_pct = '0;
    logic        us_tick = 1'b0;
    logic [6:0]  lim_a = 7'd20, lim_b = 7'd50, lim_c = 7'd80;
    logic [15:0] thr_a = 16'd3, thr_b = 16'd5, thr_c = 16'd2, thr_d = 16'd7;
    logic [15:0] interval = '0;
    logic        continuous = 1'b0, auto_cancel = 1'b0;
    logic        util_irq, timer_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    intr_moderator dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .frame_done(frame_done),
        .util_pct(util_pct), .us_tick(us_tick), .lim_a(lim_a), .lim_b(lim_b),
        .lim_c(lim_c), .thr_a(thr_a), .thr_b(thr_b), .thr_c(thr_c), .thr_d(thr_d),
        .interval(interval), .continuous(continuous), .auto_cancel(auto_cancel),
        .util_irq(util_irq), .timer_irq(timer_irq)
    );

    // Band table: utilization value and the threshold of the band it must select
    // (limits 20/50/80, thresholds A=3 B=5 C=2 D=7).
    localparam int NV = 9;
    localparam int TV_UTIL [NV] = '{0, 20, 21, 50, 51, 80, 81, 100, 127};
    localparam int TV_THR  [NV] = '{3,  3,  5,  5,  2,  2,  7,   7,   7};

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic frame();
        frame_done = 1'b1; step(); frame_done = 1'b0;
    endtask

    task automatic tick();
        us_tick = 1'b1; step(); us_tick = 1'b0;
    endtask

    task automatic restart_block();
        enable = 1'b0; step(); step();
        enable = 1'b1; step(); step();
    endtask

    initial begin
        #1;
        step(); step();
        // R9 reset state
        check("R9 util_irq in reset", util_irq, 1'b0);
        check("R9 timer_irq in reset", timer_irq, 1'b0);
        rst_n = 1'b1;
        step();
        check("R9 util_irq after reset", util_irq, 1'b0);
        enable = 1'b1; step(); step();

        // R1/R2 table walk
        for (int v = 0; v < NV; v++) begin
            util_pct = 7'(TV_UTIL[v]);
            for (int f = 1; f <= TV_THR[v]; f++) begin
                frame();
                check($sformatf("R1 R2 util=%0d frame %0d", TV_UTIL[v], f),
                      util_irq, (f == TV_THR[v]));
            end
            step();
            check("R2 pulse one cycle", util_irq, 1'b0);
        end

        // R2 threshold zero fires on every frame
        util_pct = 7'd0; thr_a = 16'd0;
        frame(); check("R2 thr0 first", util_irq, 1'b1);
        frame(); check("R2 thr0 second", util_irq, 1'b1);
        thr_a = 16'd3;
        step();

        // R8 disabled: frames ignored, counter held at zero
        enable = 1'b0; step();
        for (int f = 0; f < 4; f++) begin
            frame(); check("R8 disabled no util_irq", util_irq, 1'b0);
        end
        enable = 1'b1; step();
        frame(); check("R8 count cleared frame1", util_irq, 1'b0);
        frame(); check("R8 count cleared frame2", util_irq, 1'b0);
        frame(); check("R8 count cleared frame3", util_irq, 1'b1);

        // R4 non-continuous: no traffic -> no timer interrupt
        enable = 1'b0; interval = 16'd5; continuous = 1'b0; auto_cancel = 1'b0;
        thr_a = 16'd100; restart_block();
        for (int t = 0; t < 15; t++) begin
            tick(); check("R4 quiet no timer_irq", timer_irq, 1'b0);
        end
        frame(); step();
        for (int t = 1; t <= 5; t++) begin
            tick(); check($sformatf("R4 busy tick %0d", t), timer_irq, (t == 5));
        end
        for (int t = 1; t <= 5; t++) begin
            tick(); check("R4 traffic forgotten", timer_irq, 1'b0);
        end

        // R3 timer interrupt clears frame count
        enable = 1'b0; thr_a = 16'd3; restart_block();
        frame(); frame(); step();
        for (int t = 1; t <= 5; t++) begin
            tick(); check("R3 timer fire", timer_irq, (t == 5));
        end
        frame(); check("R3 frame1 after clear", util_irq, 1'b0);
        frame(); check("R3 frame2 after clear", util_irq, 1'b0);
        frame(); check("R3 frame3 after clear", util_irq, 1'b1);

        // R5 continuous fires without traffic
        enable = 1'b0; continuous = 1'b1; restart_block();
        for (int t = 1; t <= 10; t++) begin
            tick(); check($sformatf("R5 tick %0d", t), timer_irq, (t % 5 == 0));
        end

        // R6 without auto-cancel: original interval kept
        enable = 1'b0; auto_cancel = 1'b0; restart_block();
        tick(); tick(); tick();
        frame(); frame(); frame();
        check("R6 util fired (ac off)", util_irq, 1'b1);
        tick(); check("R6 ac off tick4", timer_irq, 1'b0);
        tick(); check("R6 ac off tick5", timer_irq, 1'b1);

        // R6 with auto-cancel: interval restarts at the utilization interrupt
        enable = 1'b0; auto_cancel = 1'b1; restart_block();
        tick(); tick(); tick();
        frame(); frame(); frame();
        check("R6 util fired (ac on)", util_irq, 1'b1);
        for (int t = 1; t <= 5; t++) begin
            tick(); check($sformatf("R6 ac on tick %0d", t), timer_irq, (t == 5));
        end

        // R7 zero interval disables timer
        enable = 1'b0; interval = 16'd0; auto_cancel = 1'b0; restart_block();
        for (int t = 0; t < 8; t++) begin
            tick(); check("R7 zero interval", timer_irq, 1'b0);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule